// File: doc/BRIEF.md
# Pattern Generator and Lock Checker

This block supports link bring-up testing with a transmit side and a receive side. The transmit side emits one 8-bit message per clock while its enable input is high. In fixed mode it alternates between two programmable patterns. In random mode it steps an 8-bit linear-feedback shift register that restarts from a fixed nonzero seed.

The receive side watches a valid/data message stream. It keeps the first two messages it ever receives and predicts each following message from the one before. After enough consecutive correct predictions it declares lock. After lock it flags and counts every wrong message in a small wrapping counter. The lock status is a 2-bit code that software or a bring-up controller can poll.

Both sides share the mode select and the two pattern inputs. Serialization and framing are handled outside the block.

Top module: `patlock_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state: `tx_valid` is 0, `lock_state` is 00, `err_count` is 0, and `rx_first` and `rx_second` are 0.
- R2: `tx_valid` is 1 in the cycle after each rising edge at which `enable` was 1, and 0 in the cycle after each rising edge at which `enable` was 0.
- R3: In fixed mode (`fixed_mode`=1), each enabled run sends `pat_a` first. It then alternates `pat_a`, `pat_b`, and so on. Dropping `enable` restarts the alternation at `pat_a`.
- R4: In random mode (`fixed_mode`=0), each enabled run sends 0xA5 first. Each following message is `{d[6:0], d[7]^d[5]^d[4]^d[3]}`, where `d` is the previous message.
- R5: `rx_first` holds the first message received after reset and `rx_second` holds the second. Neither changes afterwards.
- R6: `lock_state` stays 00 (idle) until the first valid message arrives. It then becomes 01 (calibrating).
- R7: The prediction is the other pattern in fixed mode: `pat_b` if the previous message equals `pat_a`, and `pat_a` otherwise. In random mode the prediction is the R4 step applied to the previous message. During calibration, 4 consecutive correct predictions move `lock_state` to 10 (locked). A wrong message resets the run to zero.
- R8: Once locked, a wrong message moves `lock_state` to 11 (error) and adds one to `err_count`. Only a reset leaves state 11. Wrong messages before lock never change `err_count`.
- R9: `err_count` is 6 bits wide and wraps from 63 to 0.
- R10: After lock, each prediction is made from the previous prediction, not from the received data. A single corrupted message therefore counts as exactly one error.
- R11: A cycle with `rx_valid`=0 leaves `lock_state` and `err_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows the generator to transmit |
| fixed_mode | input | 1 | 1 selects the fixed patterns, 0 selects the LFSR sequence |
| pat_a | input | 8 | First fixed pattern |
| pat_b | input | 8 | Second fixed pattern |
| tx_valid | output | 1 | Generator message valid |
| tx_data | output | 8 | Generator message |
| rx_valid | input | 1 | Received message valid |
| rx_data | input | 8 | Received message |
| rx_first | output | 8 | First received message |
| rx_second | output | 8 | Second received message |
| lock_state | output | 2 | 00 idle, 01 calibrating, 10 locked, 11 error |
| err_count | output | 6 | Errors seen after lock, wrapping |

## Verification
Every result is registered once. A generator message reflects the `enable` and mode values sampled at the previous rising edge. A lock-state, error-count or capture update reflects the message presented at the previous rising edge. The bench therefore drives every input on a falling edge and compares outputs at the next falling edge, exactly one rising edge later. Long runs such as the 64-error wrap and the lock sequences are walked one message per cycle with a check after each step of interest.

// File: rtl/patlock_pkg.sv
// Shared types and the sequence step for the pattern generator and checker.
// Assumes 8-bit messages; the LFSR taps are fixed for that width.
package patlock_pkg;
    localparam int MSG_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CAL  = 2'b01,
        ST_LOCK = 2'b10,
        ST_ERR  = 2'b11
    } lock_state_t;

    // Maximal-length Fibonacci step, taps 8,6,5,4.
    function automatic logic [MSG_W-1:0] lfsr_step(input logic [MSG_W-1:0] s);
        return {s[MSG_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/patlock_gen.sv
// Transmit side: while enabled, emits one message per clock. Fixed mode
// alternates pat_a/pat_b starting with pat_a; random mode walks the LFSR from
// SEED. Disabling returns both sequences to their start point.
// Assumes SEED is nonzero.
module patlock_gen
    import patlock_pkg::*;
#(
    parameter logic [MSG_W-1:0] SEED = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fixed_mode,
    input  logic [MSG_W-1:0] pat_a,
    input  logic [MSG_W-1:0] pat_b,
    output logic             tx_valid,
    output logic [MSG_W-1:0] tx_data
);
    logic             phase_q;
    logic [MSG_W-1:0] lfsr_q;

    // Message register and sequence state, restarted whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            phase_q  <= 1'b0;
            lfsr_q   <= SEED;
        end else if (enable) begin
            tx_valid <= 1'b1;
            tx_data  <= fixed_mode ? (phase_q ? pat_b : pat_a) : lfsr_q;
            phase_q  <= ~phase_q;
            lfsr_q   <= lfsr_step(lfsr_q);
        end else begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            phase_q  <= 1'b0;
            lfsr_q   <= SEED;
        end
    end

    p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> tx_valid);
    p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tx_valid);
    p_lfsr_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tx_valid && !fixed_mode && !$past(fixed_mode))
        |=> tx_data == lfsr_step($past(tx_data)));
endmodule

// File: rtl/patlock_capture.sv
// Keeps the first and second received messages after reset; later traffic
// never alters them.
module patlock_capture
    import patlock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [MSG_W-1:0] rx_data,
    output logic [MSG_W-1:0] rx_first,
    output logic [MSG_W-1:0] rx_second
);
    logic [1:0] seen_q;

    // Saturating arrival count steering the two capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= 2'd0;
            rx_first  <= '0;
            rx_second <= '0;
        end else if (rx_valid) begin
            if (seen_q == 2'd0) rx_first  <= rx_data;
            if (seen_q == 2'd1) rx_second <= rx_data;
            if (seen_q != 2'd2) seen_q    <= seen_q + 2'd1;
        end
    end

    p_first_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0) |=> $stable(rx_first));
    p_second_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2) |=> $stable(rx_second));
endmodule

// File: rtl/patlock_chk.sv
// Receive side: predicts each message from the previous one, counts a run of
// correct predictions to declare lock, then free-runs its prediction and
// counts mismatches in a wrapping counter. Error state is left only by reset.
// Assumes mode and patterns are held steady while traffic flows.
module patlock_chk
    import patlock_pkg::*;
#(
    parameter int LOCK_RUN = 4,
    parameter int ERR_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fixed_mode,
    input  logic [MSG_W-1:0] pat_a,
    input  logic [MSG_W-1:0] pat_b,
    input  logic             rx_valid,
    input  logic [MSG_W-1:0] rx_data,
    output lock_state_t      state,
    output logic [ERR_W-1:0] err_count
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    logic [MSG_W-1:0] prev_q;
    logic [RUN_W-1:0] run_q;
    logic [MSG_W-1:0] pred;
    logic             hit;

    // Expected value of the incoming message.
    always_comb begin
        if (fixed_mode) pred = (prev_q == pat_a) ? pat_b : pat_a;
        else            pred = lfsr_step(prev_q);
        hit = (rx_data == pred);
    end

    // Lock machine, match run, reference message and error counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            run_q     <= '0;
            prev_q    <= '0;
            err_count <= '0;
        end else if (rx_valid) begin
            case (state)
                ST_IDLE: begin
                    state  <= ST_CAL;
                    run_q  <= '0;
                    prev_q <= rx_data;
                end
                ST_CAL: begin
                    prev_q <= rx_data;
                    if (!hit) begin
                        run_q <= '0;
                    end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                        state <= ST_LOCK;
                        run_q <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end
                ST_LOCK: begin
                    prev_q <= pred;
                    if (!hit) begin
                        state     <= ST_ERR;
                        err_count <= err_count + 1'b1;
                    end
                end
                default: begin
                    prev_q <= pred;
                    if (!hit) err_count <= err_count + 1'b1;
                end
            endcase
        end
    end

    p_idle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rx_valid) |=> state == ST_CAL);
    p_no_early_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (state == ST_IDLE || state == ST_CAL)) |=> $stable(err_count));
    p_lock_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && rx_valid && !hit)
        |=> (state == ST_ERR && err_count == $past(err_count) + 1'b1));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ERR |=> state == ST_ERR);
    p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(state) && $stable(err_count)));
endmodule

// File: rtl/patlock_top.sv
// Top of the pattern generator and lock checker: joins the transmit side,
// the capture registers and the lock checker, which share mode and patterns.
module patlock_top
    import patlock_pkg::*;
#(
    parameter int               LOCK_RUN = 4,
    parameter int               ERR_W    = 6,
    parameter logic [MSG_W-1:0] SEED     = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fixed_mode,
    input  logic [MSG_W-1:0] pat_a,
    input  logic [MSG_W-1:0] pat_b,
    output logic             tx_valid,
    output logic [MSG_W-1:0] tx_data,
    input  logic             rx_valid,
    input  logic [MSG_W-1:0] rx_data,
    output logic [MSG_W-1:0] rx_first,
    output logic [MSG_W-1:0] rx_second,
    output logic [1:0]       lock_state,
    output logic [ERR_W-1:0] err_count
);
    lock_state_t chk_state;

    patlock_gen #(.SEED(SEED)) u_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fixed_mode(fixed_mode),
        .pat_a(pat_a), .pat_b(pat_b), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    patlock_capture u_cap (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_first(rx_first), .rx_second(rx_second)
    );

    patlock_chk #(.LOCK_RUN(LOCK_RUN), .ERR_W(ERR_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .fixed_mode(fixed_mode),
        .pat_a(pat_a), .pat_b(pat_b), .rx_valid(rx_valid), .rx_data(rx_data),
        .state(chk_state), .err_count(err_count)
    );

    assign lock_state = chk_state;
endmodule

// File: tb/patlock_top_test.sv
module patlock_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       fixed_mode = 1'b1;
    logic [7:0] pat_a = 8'hAA;
    logic [7:0] pat_b = 8'h55;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] rx_first, rx_second;
    logic [1:0] lock_state;
    logic [5:0] err_count;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    patlock_top uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fixed_mode(fixed_mode),
        .pat_a(pat_a), .pat_b(pat_b), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .rx_second(rx_second), .lock_state(lock_state), .err_count(err_count)
    );

    function automatic logic [7:0] step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; rx_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic v, input logic [7:0] d);
        rx_valid = v; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // {valid, data, expected state, expected err_count}, fixed mode AA/55
    localparam logic [16:0] VEC [16] = '{
        {1'b0, 8'h00, 2'b00, 6'd0},  // R11 idle holds
        {1'b1, 8'hAA, 2'b01, 6'd0},  // R6 first message
        {1'b1, 8'h55, 2'b01, 6'd0},  // R7 run 1
        {1'b1, 8'hAA, 2'b01, 6'd0},  // R7 run 2
        {1'b1, 8'hAA, 2'b01, 6'd0},  // R7 mismatch restarts
        {1'b1, 8'h55, 2'b01, 6'd0},  // R7 run 1
        {1'b1, 8'hAA, 2'b01, 6'd0},  // R7 run 2
        {1'b1, 8'h55, 2'b01, 6'd0},  // R7 run 3
        {1'b0, 8'h00, 2'b01, 6'd0},  // R11 gap
        {1'b1, 8'hAA, 2'b10, 6'd0},  // R7 run 4 locks
        {1'b1, 8'h55, 2'b10, 6'd0},  // R7 stays locked
        {1'b1, 8'h00, 2'b11, 6'd1},  // R8 first error
        {1'b1, 8'h55, 2'b11, 6'd1},  // R10 back in step
        {1'b1, 8'h55, 2'b11, 6'd2},  // R8 counted
        {1'b0, 8'h00, 2'b11, 6'd2},  // R11 gap in error
        {1'b1, 8'hAA, 2'b11, 6'd3}   // R8 sticky, counted
    };

    initial begin
        // R1 reset state
        @(negedge clk); @(negedge clk);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 lock_state", lock_state, 0);
        check("R1 err_count", err_count, 0);
        check("R1 rx_first", rx_first, 0);
        rst_n = 1'b1;

        // Table walk of the checker
        for (int i = 0; i < 16; i++) begin
            rx_valid = VEC[i][16];
            rx_data  = VEC[i][15:8];
            @(negedge clk);
            check($sformatf("R6/R7/R8/R10/R11 state vec %0d", i), lock_state, VEC[i][7:6]);
            check($sformatf("R8/R10/R11 err vec %0d", i), err_count, VEC[i][5:0]);
        end
        rx_valid = 1'b0;
        check("R5 rx_first", rx_first, 8'hAA);
        check("R5 rx_second", rx_second, 8'h55);

        // R2 / R3 fixed generator
        enable = 1'b1; fixed_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 tx_valid on", tx_valid, 1);
            check("R3 fixed order", tx_data, (i % 2 == 0) ? 8'hAA : 8'h55);
        end
        enable = 1'b0;
        @(negedge clk);
        check("R2 tx_valid off", tx_valid, 0);
        enable = 1'b1;
        @(negedge clk);
        check("R3 restart at pat_a", tx_data, 8'hAA);
        enable = 1'b0;
        @(negedge clk);

        // R4 random generator
        fixed_mode = 1'b0; enable = 1'b1;
        begin
            logic [7:0] e;
            e = 8'hA5;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                check("R4 lfsr sequence", tx_data, e);
                e = step(e);
            end
        end
        enable = 1'b0;
        @(negedge clk);

        // R7 random-mode lock, R5 capture after fresh reset
        do_reset();
        check("R1 state after reset", lock_state, 0);
        begin
            logic [7:0] v;
            v = 8'h3C;
            send(1'b1, v);
            check("R6 random cal", lock_state, 2'b01);
            for (int i = 0; i < 4; i++) begin
                v = step(v);
                send(1'b1, v);
            end
            check("R7 random lock", lock_state, 2'b10);
            v = step(v);
            send(1'b1, v);
            check("R7 random stays locked", lock_state, 2'b10);
            check("R8 no error when matching", err_count, 0);
        end
        check("R5 random first", rx_first, 8'h3C);
        check("R5 random second", rx_second, step(8'h3C));

        // R9 wrap, fixed mode
        do_reset();
        fixed_mode = 1'b1;
        send(1'b1, 8'hAA); send(1'b1, 8'h55); send(1'b1, 8'hAA);
        send(1'b1, 8'h55); send(1'b1, 8'hAA);
        check("R7 fixed lock", lock_state, 2'b10);
        for (int i = 0; i < 63; i++) send(1'b1, 8'h00);
        check("R9 count 63", err_count, 63);
        send(1'b1, 8'h00);
        check("R9 wrap to 0", err_count, 0);
        check("R8 error state held", lock_state, 2'b11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule